// File: doc/BRIEF.md
# Circular Conversion Result Readout Buffer

This block keeps up to four 12-bit conversion results and hands them to a host over a shared 12-bit data bus. The host uses two active-low strobes, a chip select and a read strobe. A read pointer picks the result that goes onto the bus. When a read strobe ends, the pointer steps to the next channel, but only if that channel's result has already been written. After the last configured channel the pointer returns to the first one, so the results can be read over and over in a circle. A first-data flag goes high whenever the pointer sits on the first result of a fresh circle.

A conversion sequencer drives the write side. Its sequence-restart pulse clears every availability bit, points the read side back at channel 0 and raises the flag. It then writes each result together with its channel index. Each write marks that channel as available. The number of configured channels sets the wrap point. All inputs are sampled on the rising clock edge. The end of a read is detected as a low-to-high change on the read strobe between two samples.

Top module: `rdbuf_top`

## Requirements
- R1: `bus_oe_o` is high, and `bus_o` carries the result at the read pointer, only while `cs_n_i` and `rd_n_i` are both low. Otherwise `bus_oe_o` is low and `bus_o` is high-impedance.
- R2: A cycle with `seq_rst_i` high sets the pointer to channel 0, sets `first_o` and clears every availability bit. It overrides a write or a read end in the same cycle.
- R3: A cycle with `wr_en_i` high (and `seq_rst_i` low) stores `wr_data_i` in register `wr_idx_i` and marks that channel available.
- R4: A read end is a sample with `rd_n_i` high directly after a sample with `rd_n_i` low, while `cs_n_i` is low. On a read end the pointer moves to the next channel only if that channel is available; otherwise it holds.
- R5: The channel count is `num_ch_i`+1 (code 0..3 means 1..4 channels). The pointer steps in ascending order 0,1,… and goes from index `num_ch_i` back to 0.
- R6: When the pointer moves, `first_o` becomes high if the new position is channel 0 and low otherwise.
- R7: A write to index 1 while the pointer is at 0 and more than one channel is configured clears `first_o`.
- R8: A low-to-high change on `rd_n_i` while `cs_n_i` is high leaves the pointer and `first_o` unchanged.
- R9: After reset, `first_o` is low, the pointer is 0, no channel is available and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| num_ch_i | input | 2 | Configured channel count minus one |
| seq_rst_i | input | 1 | Sequence restart pulse from the sequencer |
| wr_en_i | input | 1 | Result write strobe |
| wr_idx_i | input | 2 | Channel index of the written result |
| wr_data_i | input | 12 | Result value |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| bus_o | output | 12 | Data bus, high-impedance when not read |
| bus_oe_o | output | 1 | Bus drive enable |
| first_o | output | 1 | Pointer is on the first result |

## Verification
Every channel count from one to four is swept. For each count, all results are written and then read twice around the circle plus one more read. This separates a correct wrap point from an off-by-one and exposes a stuck or skipping pointer. The single-channel case checks that the flag stays high. A partial sequence, where only channel 0 is written before reading, shows whether the availability gate holds the pointer. The same sequence checks that the flag drops on the second write. Strobe-only patterns (read strobe without chip select and the reverse) show whether the bus drive and the pointer ignore half-asserted accesses.

// File: rtl/rdbuf_pkg.sv
package rdbuf_pkg;
  localparam int unsigned DEF_DATA_W   = 12;
  localparam int unsigned DEF_NUM_REGS = 4;

  typedef struct packed {
    logic rise;
    logic drive;
  } strobe_t;
endpackage

// File: rtl/rdbuf_strobe.sv
module rdbuf_strobe
  import rdbuf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cs_n_i,
  input  logic    rd_n_i,
  output strobe_t stb_o
);
  logic rd_q, rd_d;

  always_comb begin
    rd_d = rd_n_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b1;
    else        rd_q <= rd_d;
  end

  always_comb begin
    stb_o.rise  = !rd_q && rd_n_i && !cs_n_i;
    stb_o.drive = !cs_n_i && !rd_n_i;
  end

  // R8
  ignore_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |-> !stb_o.rise);
endmodule

// File: rtl/rdbuf_store.sv
module rdbuf_store #(
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_rst_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  ptr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NUM_REGS-1:0] valid_o
);
  logic [DATA_W-1:0]   data_q [NUM_REGS];
  logic [NUM_REGS-1:0] valid_q, valid_d;
  logic                wr_ok;

  assign wr_ok = wr_en_i && !seq_rst_i;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic ld;
    assign ld = wr_ok && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  data_q[g] <= '0;
      else if (ld) data_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    valid_d = valid_q;
    if (seq_rst_i)  valid_d = '0;
    else if (wr_ok) valid_d[wr_idx_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  assign rd_data_o = data_q[ptr_i];
  assign valid_o   = valid_q;

  // R2
  valid_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rst_i |=> (valid_o == '0));
  // R3
  valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !seq_rst_i) |=> valid_o[$past(wr_idx_i)]);
endmodule

// File: rtl/rdbuf_ptr.sv
module rdbuf_ptr #(
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    last_i,
  input  logic                seq_rst_i,
  input  logic                rd_rise_i,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [NUM_REGS-1:0] valid_i,
  output logic [IDX_W-1:0]    ptr_o,
  output logic                first_o
);
  logic [IDX_W-1:0] ptr_q, ptr_d, nxt;
  logic             first_q, first_d, avail;

  always_comb begin
    nxt   = (ptr_q >= last_i) ? '0 : ptr_q + 1'b1;
    avail = valid_i[nxt];
  end

  always_comb begin
    ptr_d   = ptr_q;
    first_d = first_q;
    if (seq_rst_i) begin
      ptr_d   = '0;
      first_d = 1'b1;
    end else if (rd_rise_i && avail) begin
      ptr_d   = nxt;
      first_d = (nxt == '0);
    end else if (wr_en_i && wr_idx_i == IDX_W'(1) && ptr_q == '0 && last_i != '0) begin
      first_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      first_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      first_q <= first_d;
    end
  end

  assign ptr_o   = ptr_q;
  assign first_o = first_q;

  // R2
  seq_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rst_i |=> (first_o && ptr_o == '0));
  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_rst_i || rd_rise_i) |=> $stable(ptr_o));
  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise_i && !seq_rst_i) |=> (ptr_o <= $past(last_i)));
  // R6
  first_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_o |-> (ptr_o == '0));
endmodule

// File: rtl/rdbuf_top.sv
module rdbuf_top
  import rdbuf_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  num_ch_i,
  input  logic              seq_rst_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic              first_o
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  strobe_t             stb;
  logic [IDX_W-1:0]    ptr;
  logic [DATA_W-1:0]   rd_data;
  logic [NUM_REGS-1:0] valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rdbuf_strobe u_strobe (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cs_n_i (cs_n_i),
    .rd_n_i (rd_n_i),
    .stb_o  (stb)
  );

  rdbuf_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .seq_rst_i (seq_rst_i),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .ptr_i     (ptr),
    .rd_data_o (rd_data),
    .valid_o   (valid)
  );

  rdbuf_ptr #(.NUM_REGS(NUM_REGS)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .last_i    (num_ch_i),
    .seq_rst_i (seq_rst_i),
    .rd_rise_i (stb.rise),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .valid_i   (valid),
    .ptr_o     (ptr),
    .first_o   (first_o)
  );

  assign bus_oe_o = stb.drive;
  assign bus_o    = stb.drive ? rd_data : 'z;

  // R1
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cs_n_i || rd_n_i) |-> !bus_oe_o);
endmodule

// File: tb/rdbuf_top_bench.sv
module rdbuf_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  num_ch = 2'd3;
  logic        seq_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [11:0] wr_data = '0;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic [11:0] bus;
  logic        bus_oe;
  logic        first;
  int          vecs = 0;
  int          errs = 0;

  always #4 clk = ~clk;

  rdbuf_top u_rdbuf_top (
    .clk(clk), .rst_n(rst_n), .num_ch_i(num_ch), .seq_rst_i(seq_rst),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .cs_n_i(cs_n), .rd_n_i(rd_n), .bus_o(bus), .bus_oe_o(bus_oe),
    .first_o(first)
  );

  function automatic logic [11:0] val(int cfg, int ch);
    return 12'(cfg * 256 + ch * 17 + 5);
  endfunction

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic restart();
    @(negedge clk) seq_rst = 1'b1;
    @(negedge clk) seq_rst = 1'b0;
  endtask

  task automatic wr(int idx, logic [11:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_idx = 2'(idx); wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  // full access: check drive and data, then the flag after the read end
  task automatic rd(string req, logic [11:0] exp_d, logic exp_f);
    @(negedge clk) begin cs_n = 1'b0; rd_n = 1'b0; end
    @(negedge clk) begin
      chk({req, " oe"}, 12'(bus_oe), 12'd1);
      chk({req, " data"}, bus, exp_d);
      rd_n = 1'b1;
    end
    @(negedge clk) begin
      cs_n = 1'b1;
      chk({req, " first"}, 12'(first), 12'(exp_f));
    end
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk("R9 first", 12'(first), 12'd0);
    chk("R9 oe", 12'(bus_oe), 12'd0);

    for (int cfg = 0; cfg < 4; cfg++) begin
      int n = cfg + 1;
      num_ch = 2'(cfg);
      restart();
      chk("R2 first after restart", 12'(first), 12'd1);
      for (int ch = 0; ch < n; ch++) begin
        wr(ch, val(cfg, ch));
        // R7: second write drops the flag for multi-channel configs
        chk("R7 first after write", 12'(first), (ch >= 1 && n > 1) ? 12'd0 : 12'd1);
      end
      // R3 R4 R5 R6: two full circles plus one
      for (int k = 0; k < 2 * n + 1; k++)
        rd("R5 circular read", val(cfg, k % n), ((k + 1) % n) == 0);
    end

    // R4 availability gate, 4 channels
    num_ch = 2'd3;
    restart();
    wr(0, 12'hA01);
    rd("R4 held read", 12'hA01, 1'b1);
    rd("R4 held reread", 12'hA01, 1'b1);
    wr(1, 12'hA02);
    chk("R7 flag clear", 12'(first), 12'd0);
    rd("R4 after avail", 12'hA01, 1'b0);
    rd("R4 second", 12'hA02, 1'b0);
    rd("R4 stall at 1", 12'hA02, 1'b0);

    // R1: half-asserted strobes do not drive
    @(negedge clk) begin cs_n = 1'b1; rd_n = 1'b0; end
    @(negedge clk) begin chk("R1 rd only", 12'(bus_oe), 12'd0); rd_n = 1'b1; end
    @(negedge clk) begin cs_n = 1'b0; end
    @(negedge clk) begin chk("R1 cs only", 12'(bus_oe), 12'd0); cs_n = 1'b1; end

    // R8: read strobe without select leaves pointer
    wr(2, 12'hA03);
    @(negedge clk) rd_n = 1'b0;
    @(negedge clk) rd_n = 1'b1;
    @(negedge clk);
    rd("R8 pointer unmoved", 12'hA02, 1'b0);
    rd("R8 next", 12'hA03, 1'b0);

    // R2 restart overrides a same-cycle write
    @(negedge clk) begin seq_rst = 1'b1; wr_en = 1'b1; wr_idx = 2'd0; wr_data = 12'h777; end
    @(negedge clk) begin seq_rst = 1'b0; wr_en = 1'b0; end
    wr(0, 12'h123);
    rd("R2 restart wins", 12'h123, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule